// File: doc/BRIEF.md
# I2C master register and byte sequencer

This block is the byte-level half of an I2C master controller. A host uses a bank of 8-bit registers on a plain synchronous bus (3-bit address, write data, read data, write strobe) to set a clock prescale value, enable the core, load a byte to send and issue byte-level commands. Those commands are start, write byte, read byte, stop, and the acknowledge value to return after a read. The sequencer turns each accepted command into a chain of bit commands for a separate bit-level controller, which owns the line timing. It shifts bytes out and in most significant bit first, and it reports the acknowledge it received, arbitration loss, operation progress and an interrupt flag in a status register.

A single command word may combine a start, one byte phase and a stop. Single-byte writes, multi-byte reads and repeated-start random reads are built from a short series of such commands, with the host waiting for the interrupt flag between them. The bit-level controller acknowledges each bit command with a one-cycle done pulse and returns the sampled line value with it. It can also report arbitration loss, which aborts the operation at once.

Top module: `i2c_byte_seq`

## Requirements
- R1: Register offsets are prescale low 0, prescale high 1, control 2, command 3 (write-only), status 4 (read-only), transmit 5 (write-only) and receive 6 (read-only). Write-only offsets and unused offsets read as 0. After reset the prescale reads 0xFF/0xFF and every other register reads 0x00.
- R2: A prescale write is accepted only while control bit 7 (core enable) is 0. prescale_o shows {high, low}. Control reads back only bit 7.
- R3: The command byte is bit 7 start, bit 6 stop, bit 5 read, bit 4 write, bit 3 the ack value sent after a read (0 ack, 1 no-ack) and bit 0 interrupt clear. Its operation bits are taken only while the core is enabled and no operation is pending. Status bit 1 (in progress) is 1 from acceptance until the operation ends.
- R4: bit_cmd_o is encoded 0 none, 1 start, 2 stop, 3 write, 4 read. A non-zero command is held until bit_done_i or bit_al_i, and the next command appears the cycle after bit_done_i.
- R5: The sub-operations of one command run in the order start, byte phase, ack slot, stop, each only if requested. A write bit takes priority over a read bit.
- R6: A write byte issues eight write bit commands with bit_txd_o carrying the transmit register MSB first, then one read bit command for the ack slot. The bit_rxd_i sampled there is stored in status bit 7 (1 = no-ack).
- R7: A read byte issues eight read bit commands with bit_txd_o at 1. The sampled bits, MSB first, are loaded into the receive register after the 8th bit. Then a write bit command sends the command's ack bit on bit_txd_o. Status bit 7 is not changed by a read.
- R8: When an operation ends, the command operation bits clear, status bit 0 (interrupt) is set and status bit 1 goes to 0.
- R9: A command write with bit 0 set clears the interrupt flag. If an operation ends in the same cycle, the flag stays set.
- R10: bit_al_i during an operation aborts it. bit_cmd_o returns to 0, the operation bits clear, and status bit 5 (arbitration lost) and the interrupt flag set. Status bit 5 clears when a command with the start bit is accepted.
- R11: Status bit 6 follows bus_busy_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| addr_i | input | 3 | register offset |
| wdata_i | input | 8 | host write data |
| we_i | input | 1 | host write strobe |
| rdata_o | output | 8 | register read data for addr_i |
| bus_busy_i | input | 1 | bus busy indication from the bit level |
| bit_done_i | input | 1 | bit command completed |
| bit_rxd_i | input | 1 | line value sampled by the completed bit command |
| bit_al_i | input | 1 | arbitration lost from the bit level |
| bit_cmd_o | output | 3 | bit command to the bit level |
| bit_txd_o | output | 1 | data bit for a write bit command |
| core_en_o | output | 1 | core enable |
| prescale_o | output | 16 | clock prescale value |

## Verification
Two functions can meet in one cycle: an operation finishing, which sets the interrupt flag, and a host command write that clears it. The bench's bit-level model raises the final done pulse of a write byte and forces an interrupt-clear write onto the host bus on that same clock edge. The flag must read as set afterwards, and a later clear on its own must still take it to 0. Arbitration loss in the middle of a byte is provoked in the same way, and it is judged by bit_cmd_o, the status bits and the absence of any further bit command.

// File: rtl/i2c_byte_seq_pkg.sv
package i2c_byte_seq_pkg;
  typedef enum logic [2:0] {
    BC_NOP   = 3'd0,
    BC_START = 3'd1,
    BC_STOP  = 3'd2,
    BC_WRITE = 3'd3,
    BC_READ  = 3'd4
  } bit_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BYTE, S_ACK, S_STOP
  } seq_st_e;

  localparam logic [2:0] OFS_PRE_LO = 3'd0;
  localparam logic [2:0] OFS_PRE_HI = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_CMD    = 3'd3;
  localparam logic [2:0] OFS_STAT   = 3'd4;
  localparam logic [2:0] OFS_TX     = 3'd5;
  localparam logic [2:0] OFS_RX     = 3'd6;

  localparam int CMD_STA = 7;
  localparam int CMD_STO = 6;
  localparam int CMD_RD  = 5;
  localparam int CMD_WR  = 4;
  localparam int CMD_ACK = 3;
  localparam int CMD_IACK = 0;

  localparam int ST_RXACK = 7;
  localparam int ST_BUSY  = 6;
  localparam int ST_AL    = 5;
  localparam int ST_TIP   = 1;
  localparam int ST_IRQ   = 0;

  localparam int CTRL_EN = 7;
endpackage

// File: rtl/i2c_byte_seq_regs.sv
module i2c_byte_seq_regs
  import i2c_byte_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [2*DATA_W-1:0] PRESCALE_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              bus_busy_i,
  input  logic              fin_i,
  input  logic              al_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rxack_load_i,
  input  logic              rxack_i,
  output logic              op_sta_o,
  output logic              op_sto_o,
  output logic              op_rd_o,
  output logic              op_wr_o,
  output logic              op_ack_o,
  output logic [DATA_W-1:0] txr_o,
  output logic              en_o,
  output logic [2*DATA_W-1:0] prescale_o
);
  logic [DATA_W-1:0] pre_lo_q, pre_hi_q, rx_q;
  logic sta_q, sto_q, rd_q, wr_q, ack_q;
  logic irq_q, al_q, rxack_q, en_q;
  logic wr_cmd, pending, op_acc;

  assign wr_cmd  = we_i && (addr_i == ADDR_W'(OFS_CMD));
  assign pending = sta_q | sto_q | rd_q | wr_q;
  assign op_acc  = wr_cmd && en_q && !pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {sta_q, sto_q, rd_q, wr_q, ack_q} <= '0;
    end else if (op_acc) begin
      sta_q <= wdata_i[CMD_STA];
      sto_q <= wdata_i[CMD_STO];
      rd_q  <= wdata_i[CMD_RD];
      wr_q  <= wdata_i[CMD_WR];
      ack_q <= wdata_i[CMD_ACK];
    end else if (fin_i || al_i) begin
      {sta_q, sto_q, rd_q, wr_q, ack_q} <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      al_q  <= 1'b0;
    end else begin
      if (fin_i || al_i) irq_q <= 1'b1;
      else if (wr_cmd && wdata_i[CMD_IACK]) irq_q <= 1'b0;
      if (al_i) al_q <= 1'b1;
      else if (op_acc && wdata_i[CMD_STA]) al_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_lo_q <= PRESCALE_RST[DATA_W-1:0];
      pre_hi_q <= PRESCALE_RST[2*DATA_W-1:DATA_W];
      en_q     <= 1'b0;
      txr_o    <= '0;
      rx_q     <= '0;
      rxack_q  <= 1'b0;
    end else begin
      if (we_i && !en_q && addr_i == ADDR_W'(OFS_PRE_LO)) pre_lo_q <= wdata_i;
      if (we_i && !en_q && addr_i == ADDR_W'(OFS_PRE_HI)) pre_hi_q <= wdata_i;
      if (we_i && addr_i == ADDR_W'(OFS_CTRL)) en_q <= wdata_i[CTRL_EN];
      if (we_i && addr_i == ADDR_W'(OFS_TX)) txr_o <= wdata_i;
      if (rx_load_i) rx_q <= rx_data_i;
      if (rxack_load_i) rxack_q <= rxack_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_PRE_LO): rdata_o = pre_lo_q;
      ADDR_W'(OFS_PRE_HI): rdata_o = pre_hi_q;
      ADDR_W'(OFS_CTRL):   rdata_o[CTRL_EN] = en_q;
      ADDR_W'(OFS_STAT): begin
        rdata_o[ST_RXACK] = rxack_q;
        rdata_o[ST_BUSY]  = bus_busy_i;
        rdata_o[ST_AL]    = al_q;
        rdata_o[ST_TIP]   = pending;
        rdata_o[ST_IRQ]   = irq_q;
      end
      ADDR_W'(OFS_RX):     rdata_o = rx_q;
      default:             rdata_o = '0;
    endcase
  end

  assign op_sta_o   = sta_q;
  assign op_sto_o   = sto_q;
  assign op_rd_o    = rd_q;
  assign op_wr_o    = wr_q;
  assign op_ack_o   = ack_q;
  assign en_o       = en_q;
  assign prescale_o = {pre_hi_q, pre_lo_q};

  assert_irq_on_fin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (irq_q && !pending));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && wr_cmd && wdata_i[CMD_IACK]) |=> irq_q);

  assert_pre_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(prescale_o));

  assert_al_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_i |=> (al_q && irq_q && !pending));
endmodule

// File: rtl/i2c_byte_seq_fsm.sv
module i2c_byte_seq_fsm
  import i2c_byte_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sta_i,
  input  logic              sto_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] txr_i,
  input  logic              bit_done_i,
  input  logic              bit_rxd_i,
  input  logic              bit_al_i,
  output logic [2:0]        bit_cmd_o,
  output logic              bit_txd_o,
  output logic              fin_o,
  output logic              al_o,
  output logic              rx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rxack_load_o,
  output logic              rxack_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  seq_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic go, byte_op;

  assign go      = sta_i | sto_i | rd_i | wr_i;
  assign byte_op = rd_i | wr_i;

  always_comb begin
    st_d = st_q;
    cnt_d = cnt_q;
    sr_d = sr_q;
    fin_o = 1'b0;
    al_o = 1'b0;
    rx_load_o = 1'b0;
    rxack_load_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (en_i && go) begin
        if (sta_i) st_d = S_START;
        else if (byte_op) begin
          st_d = S_BYTE; sr_d = txr_i; cnt_d = '0;
        end else st_d = S_STOP;
      end
      S_START: if (bit_done_i) begin
        if (byte_op) begin
          st_d = S_BYTE; sr_d = txr_i; cnt_d = '0;
        end else if (sto_i) st_d = S_STOP;
        else begin st_d = S_IDLE; fin_o = 1'b1; end
      end
      S_BYTE: if (bit_done_i) begin
        sr_d = {sr_q[DATA_W-2:0], bit_rxd_i};
        if (cnt_q == CNT_LAST) begin
          st_d = S_ACK;
          rx_load_o = !wr_i;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_ACK: if (bit_done_i) begin
        rxack_load_o = wr_i;
        if (sto_i) st_d = S_STOP;
        else begin st_d = S_IDLE; fin_o = 1'b1; end
      end
      S_STOP: if (bit_done_i) begin
        st_d = S_IDLE; fin_o = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    if (st_q != S_IDLE && bit_al_i) begin
      st_d = S_IDLE;
      al_o = 1'b1;
      fin_o = 1'b0;
      rx_load_o = 1'b0;
      rxack_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: bit_cmd_o = BC_START;
      S_STOP:  bit_cmd_o = BC_STOP;
      S_BYTE:  bit_cmd_o = wr_i ? BC_WRITE : BC_READ;
      S_ACK:   bit_cmd_o = wr_i ? BC_READ : BC_WRITE;
      default: bit_cmd_o = BC_NOP;
    endcase
  end

  // released line (1) whenever the master is not driving data
  assign bit_txd_o = (st_q == S_BYTE && wr_i) ? sr_q[DATA_W-1] :
                     (st_q == S_ACK && !wr_i) ? ack_i : 1'b1;
  assign rx_data_o = {sr_q[DATA_W-2:0], bit_rxd_i};
  assign rxack_o   = bit_rxd_i;

  assert_busy_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |-> go);

  assert_cmd_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cmd_o != BC_NOP && !bit_done_i && !bit_al_i) |=> $stable(bit_cmd_o));

  assert_ack_after_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ACK && $past(st_q) == S_BYTE) |-> ($past(cnt_q) == CNT_LAST));

  assert_al_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_al_i && st_q != S_IDLE) |=> (bit_cmd_o == BC_NOP));
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_byte_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [2*DATA_W-1:0] PRESCALE_RST = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                bus_busy_i,
  input  logic                bit_done_i,
  input  logic                bit_rxd_i,
  input  logic                bit_al_i,
  output logic [2:0]          bit_cmd_o,
  output logic                bit_txd_o,
  output logic                core_en_o,
  output logic [2*DATA_W-1:0] prescale_o
);
  logic sta, sto, rd, wr, ack, en;
  logic fin, al, rx_load, rxack_load, rxack;
  logic [DATA_W-1:0] txr, rx_data;

  i2c_byte_seq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESCALE_RST(PRESCALE_RST)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o, .bus_busy_i,
    .fin_i(fin), .al_i(al), .rx_load_i(rx_load), .rx_data_i(rx_data),
    .rxack_load_i(rxack_load), .rxack_i(rxack),
    .op_sta_o(sta), .op_sto_o(sto), .op_rd_o(rd), .op_wr_o(wr), .op_ack_o(ack),
    .txr_o(txr), .en_o(en), .prescale_o
  );

  i2c_byte_seq_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni, .en_i(en),
    .sta_i(sta), .sto_i(sto), .rd_i(rd), .wr_i(wr), .ack_i(ack), .txr_i(txr),
    .bit_done_i, .bit_rxd_i, .bit_al_i, .bit_cmd_o, .bit_txd_o,
    .fin_o(fin), .al_o(al), .rx_load_o(rx_load), .rx_data_o(rx_data),
    .rxack_load_o(rxack_load), .rxack_o(rxack)
  );

  assign core_en_o = en;
endmodule

// File: tb/test_i2c_byte_seq.sv
module test_i2c_byte_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 2;

  typedef struct {
    logic [2:0] cmd;
    logic       txd;
    logic       chk_txd;
    logic       rxd;
    logic       al;
    logic       iack;
    string      req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic h_we = 1'b0, m_we = 1'b0;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic we, bus_busy = 1'b0, bit_done = 1'b0, bit_rxd = 1'b1, bit_al = 1'b0;
  logic [2:0] bit_cmd;
  logic bit_txd, core_en;
  logic [15:0] prescale;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0, wcnt = 0;
  bit ended = 1'b0;

  assign we    = h_we | m_we;
  assign addr  = m_we ? 3'd3 : h_addr;
  assign wdata = m_we ? 8'h01 : h_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_seq i_i2c_byte_seq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .bus_busy_i(bus_busy), .bit_done_i(bit_done),
    .bit_rxd_i(bit_rxd), .bit_al_i(bit_al), .bit_cmd_o(bit_cmd),
    .bit_txd_o(bit_txd), .core_en_o(core_en), .prescale_o(prescale)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    h_addr = a;
    #1 d = rdata;
  endtask

  task automatic push(input logic [2:0] c, input logic t, input logic ct,
                      input logic r, input logic a, input logic ia, input string req);
    item_t it;
    it.cmd = c; it.txd = t; it.chk_txd = ct; it.rxd = r;
    it.al = a; it.iack = ia; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic push_wbyte(input logic [7:0] b, input logic ackrx, input logic ia);
    for (int i = 7; i >= 0; i--) push(3'd3, b[i], 1'b1, 1'b1, 1'b0, 1'b0, "R6 write bit");
    push(3'd4, 1'b1, 1'b0, ackrx, 1'b0, ia, "R6 ack slot");
  endtask

  task automatic push_rbyte(input logic [7:0] b, input logic ackv);
    for (int i = 7; i >= 0; i--) push(3'd4, 1'b1, 1'b1, b[i], 1'b0, 1'b0, "R7 read bit");
    push(3'd3, ackv, 1'b1, 1'b1, 1'b0, 1'b0, "R7 ack sent");
  endtask

  task automatic wait_q;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // bit-level model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      bit_done = 1'b0; bit_al = 1'b0; m_we = 1'b0;
      if (rst_n && bit_cmd != 3'd0) begin
        if (wcnt < DLY) wcnt++;
        else begin
          wcnt = 0;
          if (exp_q.size() == 0) chk(1'b0, "R5 unexpected bit cmd", bit_cmd, 0);
          else begin
            item_t it;
            it = exp_q.pop_front();
            chk(bit_cmd == it.cmd, {it.req, " cmd R4"}, bit_cmd, it.cmd);
            if (it.chk_txd) chk(bit_txd == it.txd, {it.req, " txd"}, bit_txd, it.txd);
            bit_rxd = it.rxd;
            if (it.al) bit_al = 1'b1; else bit_done = 1'b1;
            if (it.iack) m_we = 1'b1;
          end
        end
      end else wcnt = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and map
    hrd(3'd0, d); chk(d == 8'hFF, "R1 pre lo rst", d, 8'hFF);
    hrd(3'd1, d); chk(d == 8'hFF, "R1 pre hi rst", d, 8'hFF);
    hrd(3'd2, d); chk(d == 8'h00, "R1 ctrl rst", d, 0);
    hrd(3'd4, d); chk(d == 8'h00, "R1 status rst", d, 0);
    hrd(3'd6, d); chk(d == 8'h00, "R1 rx rst", d, 0);
    chk(bit_cmd == 3'd0, "R4 nop at reset", bit_cmd, 0);

    // R2 prescale while disabled
    hwr(3'd0, 8'h34); hwr(3'd1, 8'h12);
    hrd(3'd0, d); chk(d == 8'h34, "R2 pre lo", d, 8'h34);
    chk(prescale == 16'h1234, "R2 prescale_o", prescale, 16'h1234);

    // R3 command ignored while disabled
    hwr(3'd3, 8'h90);
    repeat (5) @(negedge clk);
    chk(bit_cmd == 3'd0, "R3 disabled cmd", bit_cmd, 0);
    hrd(3'd4, d); chk(d[1] == 1'b0, "R3 disabled tip", d[1], 0);

    hwr(3'd2, 8'hFF);
    hrd(3'd2, d); chk(d == 8'h80, "R2 ctrl readback", d, 8'h80);
    chk(core_en == 1'b1, "R2 core_en_o", core_en, 1);
    hwr(3'd0, 8'h99);
    hrd(3'd0, d); chk(d == 8'h34, "R2 pre locked", d, 8'h34);
    chk(prescale == 16'h1234, "R2 prescale_o locked", prescale, 16'h1234);
    hwr(3'd6, 8'h77);
    hrd(3'd3, d); chk(d == 8'h00, "R1 cmd reads 0", d, 0);
    hrd(3'd5, d); chk(d == 8'h00, "R1 tx reads 0", d, 0);
    hrd(3'd6, d); chk(d == 8'h00, "R1 rx not writable", d, 0);

    // R11
    bus_busy = 1'b1;
    hrd(3'd4, d); chk(d[6] == 1'b1, "R11 busy", d[6], 1);
    bus_busy = 1'b0;
    hrd(3'd4, d); chk(d[6] == 1'b0, "R11 idle", d[6], 0);

    // write: start + address byte
    hwr(3'd5, 8'hA0);
    push(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 start");
    push_wbyte(8'hA0, 1'b0, 1'b0);
    hwr(3'd3, 8'h90);
    hrd(3'd4, d); chk(d[1] == 1'b1, "R3 tip while busy", d[1], 1);
    wait_q;
    hrd(3'd4, d);
    chk(d[0] == 1'b1, "R8 irq", d[0], 1);
    chk(d[1] == 1'b0, "R8 tip cleared", d[1], 0);
    chk(d[7] == 1'b0, "R6 rxack ack", d[7], 0);
    hwr(3'd3, 8'h01);
    hrd(3'd4, d); chk(d[0] == 1'b0, "R9 iack", d[0], 0);

    // data byte, no-ack, stop
    hwr(3'd5, 8'h3C);
    push_wbyte(8'h3C, 1'b1, 1'b0);
    push(3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 stop");
    hwr(3'd3, 8'h50);
    wait_q;
    hrd(3'd4, d);
    chk(d[7] == 1'b1, "R6 rxack nack", d[7], 1);
    chk(d[0] == 1'b1, "R8 irq after stop", d[0], 1);
    hwr(3'd3, 8'h01);

    // random read: address, register byte, repeated start, read
    hwr(3'd5, 8'hA0);
    push(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 start");
    push_wbyte(8'hA0, 1'b0, 1'b0);
    hwr(3'd3, 8'h90); wait_q; hwr(3'd3, 8'h01);
    hwr(3'd5, 8'h07);
    push_wbyte(8'h07, 1'b0, 1'b0);
    hwr(3'd3, 8'h10); wait_q; hwr(3'd3, 8'h01);
    hwr(3'd5, 8'hA1);
    push(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 repeated start");
    push_wbyte(8'hA1, 1'b0, 1'b0);
    hwr(3'd3, 8'h90); wait_q; hwr(3'd3, 8'h01);
    push_rbyte(8'hC3, 1'b0);
    hwr(3'd3, 8'h20); wait_q;
    hrd(3'd6, d); chk(d == 8'hC3, "R7 rx byte ack", d, 8'hC3);
    hwr(3'd3, 8'h01);
    push_rbyte(8'h5B, 1'b1);
    push(3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 stop after read");
    hwr(3'd3, 8'h68); wait_q;
    hrd(3'd6, d); chk(d == 8'h5B, "R7 rx byte nack", d, 8'h5B);
    hrd(3'd4, d); chk(d[7] == 1'b0, "R7 rxack untouched", d[7], 0);
    hwr(3'd3, 8'h01);

    // R9 completion and interrupt clear in one cycle
    hwr(3'd5, 8'h55);
    push_wbyte(8'h55, 1'b0, 1'b1);
    hwr(3'd3, 8'h10); wait_q;
    hrd(3'd4, d); chk(d[0] == 1'b1, "R9 set wins", d[0], 1);
    hwr(3'd3, 8'h01);
    hrd(3'd4, d); chk(d[0] == 1'b0, "R9 later clear", d[0], 0);

    // R10 arbitration lost mid-byte
    hwr(3'd5, 8'h80);
    push(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 start");
    push(3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10 bit7");
    push(3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 lost");
    hwr(3'd3, 8'h90); wait_q;
    repeat (6) @(negedge clk);
    chk(bit_cmd == 3'd0, "R10 nop after loss", bit_cmd, 0);
    hrd(3'd4, d);
    chk(d[5] == 1'b1, "R10 al flag", d[5], 1);
    chk(d[0] == 1'b1, "R10 irq", d[0], 1);
    chk(d[1] == 1'b0, "R10 tip cleared", d[1], 0);
    hwr(3'd3, 8'h01);
    push(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 new start");
    hwr(3'd3, 8'h80); wait_q;
    hrd(3'd4, d);
    chk(d[5] == 1'b0, "R10 al cleared", d[5], 0);
    chk(d[0] == 1'b1, "R8 start-only irq", d[0], 1);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule